// File: doc/BRIEF.md
# MSI Doorbell to Interrupt Line Translator

This block is a small memory-mapped register frame that converts message-signalled interrupt writes into one-cycle pulses on a bank of shared interrupt lines. A device writes an absolute interrupt number to the doorbell register. The frame subtracts the first number of its window, which is the configured base plus 32. If the result falls inside the window, the frame pulses the matching local output line. Any number outside the window is dropped without a response.

Two elaboration parameters set the window: the base and the line count. Software can read the window back from a type register, and the frame also serves a fixed interface-identity register and a range of identification words that all read as zero. The slave is a plain 32-bit register port. Each access is presented for one cycle with an address, a direction, a byte size and write data. Read data and an error flag return combinationally in the same cycle.

A parameter pair that breaks the window limits still elaborates. In that case the frame raises a sticky configuration-error output and stops issuing pulses.

Top module: `msi_spi_bridge`

## Requirements
- R1: A 4-byte read at offset 0x008 returns (BASE_IRQ+32) in bits [31:16] and IRQ_COUNT in bits [15:0], with the error flag low.
- R2: A 4-byte read at offset 0xFCC returns 0x51 in bits [27:20] and zero in every other bit, with the error flag low.
- R3: A 4-byte read at any offset from 0xFD0 through 0xFFC inclusive returns zero, with the error flag low.
- R4: A read whose size is not 4 bytes, or a read at any other offset, returns zero and raises the error flag in the same cycle.
- R5: A write of size 2 or 4 to offset 0x040 takes data bits [9:0] as an interrupt number N. If BASE_IRQ+32 <= N < BASE_IRQ+32+IRQ_COUNT, then in the cycle after the write exactly output bit N-(BASE_IRQ+32) is high, for one cycle only.
- R6: A doorbell write whose number lies outside the window produces no pulse and does not raise the error flag. Data bits above bit 9 have no effect on the result.
- R7: A doorbell write of any size other than 2 or 4 bytes produces no pulse and raises the error flag.
- R8: A write to any offset other than 0x040 produces no pulse and raises the error flag.
- R9: Doorbell writes on consecutive cycles produce pulses on consecutive cycles, including repeated writes of the same number.
- R10: If IRQ_COUNT > 128 or BASE_IRQ+32+IRQ_COUNT > 1020, cfg_bad is high during and after reset and stays high, and no doorbell write produces a pulse. For a legal configuration cfg_bad is low after reset.
- R11: A synchronous active-high reset clears every output pulse, including a pulse requested by a write in the reset cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset within the 4 KB frame |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4) |
| acc_wdata | input | 32 | Write data, little-endian |
| acc_rdata | output | 32 | Read data, valid in the access cycle |
| acc_err | output | 1 | Access ignored for bad size or undecoded offset |
| irq_pulse | output | IRQ_COUNT | One-cycle interrupt pulses, one per line |
| cfg_bad | output | 1 | Sticky illegal-configuration indication |

## Verification
The bench rings the doorbell with every 10-bit number, at both legal sizes and with junk in the upper data bits. This sweep separates the lower and upper window edges and the index arithmetic from data-masking faults. It also tries each illegal size and each undecoded offset for both reads and writes, and sweeps every byte offset of the identification range, which exposes errors in the decode bounds. Back-to-back writes of repeated and neighbouring numbers, together with a write issued in a reset cycle, test the pulse timing. A second instance with an out-of-limit window shows that the configuration error is sticky and that pulses are suppressed.

// File: rtl/msi_bridge_pkg.sv
package msi_bridge_pkg;

   localparam int unsigned OFF_TYPE    = 32'h008;
   localparam int unsigned OFF_BELL    = 32'h040;
   localparam int unsigned OFF_IFACE   = 32'hFCC;
   localparam int unsigned OFF_ID_LO   = 32'hFD0;
   localparam int unsigned OFF_ID_HI   = 32'hFFC;

   localparam int unsigned ID_SHIFT    = 32;
   localparam int unsigned MAX_LINES   = 128;
   localparam int unsigned MAX_INTID   = 1020;
   localparam int unsigned ID_BITS     = 10;

   typedef enum logic [1:0] {
      RSEL_NONE  = 2'd0,
      RSEL_TYPE  = 2'd1,
      RSEL_IFACE = 2'd2,
      RSEL_ZERO  = 2'd3
   } rsel_t;

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
   import msi_bridge_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              valid,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   output rsel_t             rsel,
   output logic              bell_wr,
   output logic              bad_acc
);

   logic size_rd_ok;
   logic size_wr_ok;
   logic at_type, at_iface, at_idrange, at_bell;
   logic rd_known;

   always_comb begin
      size_rd_ok = (size == 3'd4);
      size_wr_ok = (size == 3'd2) || (size == 3'd4);
      at_type    = (addr == ADDR_W'(OFF_TYPE));
      at_iface   = (addr == ADDR_W'(OFF_IFACE));
      at_bell    = (addr == ADDR_W'(OFF_BELL));
      at_idrange = (addr >= ADDR_W'(OFF_ID_LO)) && (addr <= ADDR_W'(OFF_ID_HI));
      rd_known   = at_type || at_iface || at_idrange;
   end

   always_comb begin
      rsel    = RSEL_NONE;
      bell_wr = 1'b0;
      bad_acc = 1'b0;
      if (valid) begin
         if (write) begin
            bell_wr = size_wr_ok && at_bell;
            bad_acc = !(size_wr_ok && at_bell);
         end else begin
            bad_acc = !(size_rd_ok && rd_known);
            if (size_rd_ok) begin
               if (at_type)         rsel = RSEL_TYPE;
               else if (at_iface)   rsel = RSEL_IFACE;
               else if (at_idrange) rsel = RSEL_ZERO;
            end
         end
      end
   end

endmodule

// File: rtl/msi_id_mapper.sv
module msi_id_mapper
   import msi_bridge_pkg::*;
#(
   parameter int unsigned WIN_LO    = 32,
   parameter int unsigned IRQ_COUNT = 64,
   parameter int unsigned IDX_W     = 6
) (
   input  logic               ring,
   input  logic               block,
   input  logic [ID_BITS-1:0] intid,
   output logic               fire,
   output logic [IDX_W-1:0]   idx
);

   localparam int unsigned WIN_END = WIN_LO + IRQ_COUNT;

   logic [31:0] id_ext;
   logic [31:0] offset;
   logic        in_win;

   always_comb begin
      id_ext = {{(32-ID_BITS){1'b0}}, intid};
      offset = id_ext - WIN_LO;
      in_win = (id_ext >= WIN_LO) && (id_ext < WIN_END);
      fire   = ring && !block && in_win;
      idx    = offset[IDX_W-1:0];
   end

endmodule

// File: rtl/msi_pulse_bank.sv
module msi_pulse_bank #(
   parameter int unsigned IRQ_COUNT = 64,
   parameter int unsigned IDX_W     = 6
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 fire,
   input  logic [IDX_W-1:0]     idx,
   output logic [IRQ_COUNT-1:0] pulse
);

   for (genvar g = 0; g < IRQ_COUNT; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (rst) pulse[g] <= 1'b0;
         else     pulse[g] <= fire && (idx == IDX_W'(g));
      end
   end

   AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(pulse)) else $error("more than one line pulsed"); // R5

   AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
      (pulse != '0) |-> $past(fire)) else $error("pulse without request"); // R5

endmodule

// File: rtl/msi_spi_bridge.sv
module msi_spi_bridge
   import msi_bridge_pkg::*;
#(
   parameter int unsigned BASE_IRQ     = 0,
   parameter int unsigned IRQ_COUNT    = 64,
   parameter int unsigned ADDR_W       = 12,
   parameter logic [7:0]  PRODUCT_CODE = 8'h51
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 acc_valid,
   input  logic                 acc_write,
   input  logic [ADDR_W-1:0]    acc_addr,
   input  logic [2:0]           acc_size,
   input  logic [31:0]          acc_wdata,
   output logic [31:0]          acc_rdata,
   output logic                 acc_err,
   output logic [IRQ_COUNT-1:0] irq_pulse,
   output logic                 cfg_bad
);

   localparam int unsigned WIN_LO  = BASE_IRQ + ID_SHIFT;
   localparam int unsigned IDX_W   = (IRQ_COUNT > 1) ? $clog2(IRQ_COUNT) : 1;
   localparam bit          ILLEGAL = (IRQ_COUNT > MAX_LINES) ||
                                     (WIN_LO + IRQ_COUNT > MAX_INTID);
   localparam logic [31:0] TYPE_WORD  = {16'(WIN_LO), 16'(IRQ_COUNT)};
   localparam logic [31:0] IFACE_WORD = {4'h0, PRODUCT_CODE, 20'h0};

   if (IRQ_COUNT < 1) begin : g_chk_count
      $error("IRQ_COUNT must be at least 1");
   end
   if (ADDR_W < 12) begin : g_chk_addr
      $error("ADDR_W must cover the 4 KB frame");
   end

   rsel_t             rsel;
   logic              bell_wr;
   logic              fire;
   logic [IDX_W-1:0]  idx;
   logic              cfg_q;

   msi_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
      .valid   (acc_valid),
      .write   (acc_write),
      .addr    (acc_addr),
      .size    (acc_size),
      .rsel    (rsel),
      .bell_wr (bell_wr),
      .bad_acc (acc_err)
   );

   always_comb begin
      unique case (rsel)
         RSEL_TYPE:  acc_rdata = TYPE_WORD;
         RSEL_IFACE: acc_rdata = IFACE_WORD;
         default:    acc_rdata = 32'h0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) cfg_q <= ILLEGAL;
      else     cfg_q <= cfg_q | ILLEGAL;
   end
   assign cfg_bad = cfg_q;

   msi_id_mapper #(
      .WIN_LO    (WIN_LO),
      .IRQ_COUNT (IRQ_COUNT),
      .IDX_W     (IDX_W)
   ) u_map (
      .ring  (bell_wr),
      .block (cfg_q),
      .intid (acc_wdata[ID_BITS-1:0]),
      .fire  (fire),
      .idx   (idx)
   );

   msi_pulse_bank #(
      .IRQ_COUNT (IRQ_COUNT),
      .IDX_W     (IDX_W)
   ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .fire  (fire),
      .idx   (idx),
      .pulse (irq_pulse)
   );

   AST_ERR_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && acc_err) |=> (irq_pulse == '0)) else $error("ignored access pulsed"); // R7 R8

   AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && !acc_write && acc_err) |-> (acc_rdata == 32'h0)) else $error("bad read data"); // R4

   AST_READ_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && !acc_write) |=> (irq_pulse == '0)) else $error("read caused pulse"); // R5

   AST_CFG_STICKY: assert property (@(posedge clk) disable iff (rst)
      cfg_bad |=> cfg_bad) else $error("config error cleared"); // R10

   AST_CFG_SILENT: assert property (@(posedge clk) disable iff (rst)
      cfg_bad |=> (irq_pulse == '0)) else $error("pulse under bad config"); // R10

endmodule

// File: tb/msi_spi_bridge_test.sv
module msi_spi_bridge_test;

   localparam int unsigned BASE   = 4;
   localparam int unsigned COUNT  = 8;
   localparam int unsigned LO     = BASE + 32;
   localparam int unsigned BBASE  = 960;
   localparam int unsigned BCOUNT = 64;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              acc_valid = 1'b0;
   logic              acc_write = 1'b0;
   logic [11:0]       acc_addr = '0;
   logic [2:0]        acc_size = 3'd4;
   logic [31:0]       acc_wdata = '0;
   logic [31:0]       acc_rdata, rdata_b;
   logic              acc_err, err_b;
   logic [COUNT-1:0]  irq;
   logic [BCOUNT-1:0] irq_b;
   logic              cfg_bad, cfg_bad_b;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   always #5 clk = ~clk;

   msi_spi_bridge #(.BASE_IRQ(BASE), .IRQ_COUNT(COUNT)) uut (
      .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .acc_err(acc_err), .irq_pulse(irq), .cfg_bad(cfg_bad)
   );

   msi_spi_bridge #(.BASE_IRQ(BBASE), .IRQ_COUNT(BCOUNT)) uut_cfg (
      .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
      .acc_rdata(rdata_b), .acc_err(err_b), .irq_pulse(irq_b), .cfg_bad(cfg_bad_b)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, input logic [2:0] sz,
                     input logic [31:0] exp_d, input logic exp_e, input string req);
      @(negedge clk);
      acc_valid = 1; acc_write = 0; acc_addr = a; acc_size = sz;
      #1;
      check(req, 64'(acc_rdata), 64'(exp_d));
      check(req, 64'(acc_err), 64'(exp_e));
      @(negedge clk);
      acc_valid = 0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [2:0] sz, input logic [31:0] d,
                     input logic exp_e, input string req);
      logic [9:0] n;
      logic [COUNT-1:0] exp_p;
      n = d[9:0];
      exp_p = '0;
      if (!exp_e && a == 12'h040 && n >= LO && n < LO + COUNT) exp_p[n - LO] = 1'b1;
      @(negedge clk);
      acc_valid = 1; acc_write = 1; acc_addr = a; acc_size = sz; acc_wdata = d;
      #1;
      check(req, 64'(acc_err), 64'(exp_e));
      @(negedge clk);
      acc_valid = 0;
      #1;
      check(req, 64'(irq), 64'(exp_p));
      check("R10", 64'(irq_b), 64'(0));
      @(negedge clk);
      #1;
      check(req, 64'(irq), 64'(0));
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      #1;
      check("R10", 64'(cfg_bad_b), 64'(1));
      rst = 0;
      @(negedge clk);
      #1;
      check("R11", 64'(irq), 64'(0));
      check("R10", 64'(cfg_bad), 64'(0));
      check("R10", 64'(cfg_bad_b), 64'(1));

      // R1 R2 type and identity words
      rd(12'h008, 3'd4, {16'(LO), 16'(COUNT)}, 1'b0, "R1");
      rd(12'hFCC, 3'd4, 32'h0510_0000, 1'b0, "R2");
      // R3 whole identification range, every byte offset
      for (int a = 'hFD0; a <= 'hFFC; a++) rd(12'(a), 3'd4, 32'h0, 1'b0, "R3");
      rd(12'hFCF, 3'd4, 32'h0, 1'b1, "R4");
      // R4 bad sizes and undecoded offsets
      rd(12'h008, 3'd2, 32'h0, 1'b1, "R4");
      rd(12'h008, 3'd1, 32'h0, 1'b1, "R4");
      rd(12'hFCC, 3'd3, 32'h0, 1'b1, "R4");
      rd(12'h000, 3'd4, 32'h0, 1'b1, "R4");
      rd(12'h040, 3'd4, 32'h0, 1'b1, "R4");
      rd(12'h00C, 3'd4, 32'h0, 1'b1, "R4");

      // R5 R6 full sweep of interrupt numbers, both legal sizes, junk above bit 9
      for (int n = 0; n < 1024; n++) begin
         logic [31:0] d;
         d = (n % 2 == 1) ? (32'hFFFF_FC00 | 32'(n)) : 32'(n);
         wr(12'h040, (n % 4 < 2) ? 3'd4 : 3'd2, d, 1'b0,
            (n >= LO && n < LO + COUNT) ? "R5" : "R6");
      end

      // R7 bad write sizes
      wr(12'h040, 3'd1, 32'(LO), 1'b1, "R7");
      wr(12'h040, 3'd3, 32'(LO + 1), 1'b1, "R7");
      wr(12'h040, 3'd0, 32'(LO + 2), 1'b1, "R7");
      // R8 other offsets
      wr(12'h008, 3'd4, 32'(LO), 1'b1, "R8");
      wr(12'h044, 3'd4, 32'(LO), 1'b1, "R8");
      wr(12'hFCC, 3'd4, 32'(LO + 3), 1'b1, "R8");
      wr(12'h03C, 3'd2, 32'(LO + 3), 1'b1, "R8");

      // R9 back-to-back: LO, LO, LO+1, LO+7
      @(negedge clk);
      acc_valid = 1; acc_write = 1; acc_addr = 12'h040; acc_size = 3'd4;
      acc_wdata = 32'(LO);
      @(negedge clk);
      #1 check("R9", 64'(irq), 64'(1));
      acc_wdata = 32'(LO);
      @(negedge clk);
      #1 check("R9", 64'(irq), 64'(1));
      acc_wdata = 32'(LO + 1);
      @(negedge clk);
      #1 check("R9", 64'(irq), 64'(2));
      acc_wdata = 32'(LO + 7);
      @(negedge clk);
      #1 check("R9", 64'(irq), 64'(8'h80));
      acc_valid = 0;
      @(negedge clk);
      #1 check("R9", 64'(irq), 64'(0));

      // R10 doorbell inside the illegal instance's window
      @(negedge clk);
      acc_valid = 1; acc_write = 1; acc_addr = 12'h040; acc_size = 3'd4;
      acc_wdata = 32'(BBASE + 32);
      @(negedge clk);
      acc_valid = 0;
      #1 check("R10", 64'(irq_b), 64'(0));

      // R11 write during reset gives no pulse; bad config survives reset
      @(negedge clk);
      rst = 1;
      acc_valid = 1; acc_write = 1; acc_addr = 12'h040; acc_size = 3'd4;
      acc_wdata = 32'(LO + 2);
      @(negedge clk);
      acc_valid = 0;
      #1 check("R11", 64'(irq), 64'(0));
      check("R10", 64'(cfg_bad_b), 64'(1));
      rst = 0;
      @(negedge clk);
      #1 check("R11", 64'(irq), 64'(0));
      check("R10", 64'(cfg_bad_b), 64'(1));
      check("R10", 64'(cfg_bad), 64'(0));

      wr(12'h040, 3'd4, 32'(LO + 4), 1'b0, "R5");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule